// File: doc/BRIEF.md
# Software Store Read-Sequence Detector

This block watches the access stream of a byte-wide static memory port and looks for a fixed key of six reads. Upstream logic has already turned the chip-select, output-enable and write-enable pins into one event per clock. Each event carries a valid strobe, a read or write type and a 15-bit address. When six reads hit six chosen addresses in a set order, with nothing else between them, the block raises a one-cycle store request toward the nonvolatile store controller.

Any write inside the key cancels the partial match. So does any read of an address that is not the next one expected. A cancelled key produces no store. A read of the first key address always begins a fresh attempt, even when it arrives as the mismatching access. Once a store has been requested, the block ignores all traffic until the controller signals completion. The reads in the key are only observed here. They still return normal memory data to the host through the ordinary path. The six key addresses are parameters. The current match position is brought out as a debug output.

Top module: `swstore_seq_detect`

## Requirements
- R1: While rst_n is low and on the first cycle after it, store_req is 0 and match_idx is 0, and no store is pending.
- R2: acc_write=0 marks a read and acc_write=1 a write. Key slot i is SEQ_ADDRS[i*15 +: 15]. With no store pending, a valid read whose address equals slot match_idx, where match_idx < 5, makes match_idx increase by one on the next cycle.
- R3: With no store pending, a valid read of slot 5 while match_idx is 5 makes store_req 1 for exactly the one cycle after that clock edge, and match_idx returns to 0.
- R4: With no store pending, a valid write at any match position returns match_idx to 0, and no store_req follows.
- R5: With no store pending, a valid read whose address is neither slot match_idx nor slot 0 returns match_idx to 0, and no store_req follows.
- R6: With no store pending, a valid read of slot 0 that does not match slot match_idx sets match_idx to 1.
- R7: From the request until completion, every access is ignored. A complete key gives no store_req, and match_idx stays 0.
- R8: A store_done pulse while a store is pending lets accesses from the next cycle on be accepted. A store_done pulse with no store pending has no effect.
- R9: A cycle with acc_valid low leaves match_idx unchanged and gives no store_req, whatever acc_write and acc_addr hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access event this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 15 | Byte address of the access |
| store_done | input | 1 | Store controller has finished the store |
| store_req | output | 1 | One-cycle software store request |
| match_idx | output | 3 | Number of key reads matched so far (debug) |

## Verification
The hardest state to reach from the ports is a completed key followed by accesses while the store is still pending. Random addresses almost never hit six key slots in order. To get there, the stimulus chooses among four moves with weights: the next expected address, the first key address, a random address and a write. It raises store_done only now and then, so full keys often land inside the pending window. Directed runs add a key aborted at each kind of point, a restart through slot 0, idle cycles that carry key addresses, and a stray store_done.

// File: rtl/swst_pkg.sv
package swst_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD    = 2'd0,
    SEQ_ADV     = 2'd1,
    SEQ_RESTART = 2'd2,
    SEQ_CLEAR   = 2'd3
  } seq_act_e;

  // Decide how the match position moves for one accepted (or absent) event.
  function automatic seq_act_e seq_decide(logic ev, logic is_rd, logic hit_cur,
                                          logic hit_first);
    seq_act_e a;
    if (!ev)                 a = SEQ_HOLD;
    else if (is_rd && hit_cur)   a = SEQ_ADV;
    else if (is_rd && hit_first) a = SEQ_RESTART;
    else                     a = SEQ_CLEAR;
    return a;
  endfunction

endpackage

// File: rtl/swst_addr_match.sv
module swst_addr_match #(
  parameter int ADDR_W = 15,
  parameter int STEPS  = 6,
  parameter int IDX_W  = 3,
  parameter logic [STEPS*ADDR_W-1:0] SEQ_ADDRS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  step,
  output logic              hit_cur,
  output logic              hit_first
);

  logic [STEPS-1:0] hit_vec;

  for (genvar g = 0; g < STEPS; g++) begin : g_cmp
    assign hit_vec[g] = (addr == SEQ_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    hit_cur = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (step == IDX_W'(i)) hit_cur = hit_vec[i];
    end
  end

  assign hit_first = hit_vec[0];

endmodule

// File: rtl/swst_step_track.sv
module swst_step_track
  import swst_pkg::*;
#(
  parameter int STEPS = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_ev,
  input  logic             acc_write,
  input  logic             hit_cur,
  input  logic             hit_first,
  output logic [IDX_W-1:0] step,
  output logic             fire,
  output logic             store_req
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  seq_act_e         act;
  logic [IDX_W-1:0] step_nxt;

  assign act  = seq_decide(acc_ev, ~acc_write, hit_cur, hit_first);
  assign fire = (act == SEQ_ADV) && (step == LAST);

  always_comb begin
    unique case (act)
      SEQ_ADV:     step_nxt = fire ? '0 : step + 1'b1;
      SEQ_RESTART: step_nxt = IDX_W'(1);
      SEQ_CLEAR:   step_nxt = '0;
      default:     step_nxt = step;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      store_req <= 1'b0;
    end else begin
      step      <= step_nxt;
      store_req <= fire;
    end
  end

  p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && !acc_write && hit_cur && step != LAST) |=> step == $past(step) + 1'b1);
  p_write_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && acc_write) |=> (step == '0 && !store_req));
  p_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && !acc_write && !hit_cur && !hit_first) |=> step == '0);
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && !acc_write && !hit_cur && hit_first) |=> step == IDX_W'(1));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ev |=> ($stable(step) && !store_req));
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);

endmodule

// File: rtl/swst_busy_hold.sv
module swst_busy_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy
);

  always_ff @(posedge clk) begin
    if (!rst_n)      busy <= 1'b0;
    else if (start)  busy <= 1'b1;
    else if (done)   busy <= 1'b0;
  end

  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  p_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

endmodule

// File: rtl/swstore_seq_detect.sv
module swstore_seq_detect #(
  parameter int ADDR_W = 15,
  parameter int STEPS  = 6,
  parameter logic [STEPS*ADDR_W-1:0] SEQ_ADDRS = {
    15'h7396, 15'h2C0D, 15'h54E7, 15'h0F93, 15'h6B21, 15'h1A5C},
  localparam int IDX_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              store_done,
  output logic              store_req,
  output logic [IDX_W-1:0]  match_idx
);

  logic busy;
  logic accept;
  logic hit_cur;
  logic hit_first;
  logic fire;

  assign accept = acc_valid & ~busy;

  swst_addr_match #(
    .ADDR_W(ADDR_W), .STEPS(STEPS), .IDX_W(IDX_W), .SEQ_ADDRS(SEQ_ADDRS)
  ) u_match (
    .addr      (acc_addr),
    .step      (match_idx),
    .hit_cur   (hit_cur),
    .hit_first (hit_first)
  );

  swst_step_track #(
    .STEPS(STEPS), .IDX_W(IDX_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ev    (accept),
    .acc_write (acc_write),
    .hit_cur   (hit_cur),
    .hit_first (hit_first),
    .step      (match_idx),
    .fire      (fire),
    .store_req (store_req)
  );

  swst_busy_hold u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire),
    .done  (store_done),
    .busy  (busy)
  );

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  p_req_idx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> (match_idx == '0 && busy));
  p_idx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> match_idx == '0);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!store_req && match_idx == '0 && !busy));

endmodule

// File: tb/sim_swstore_seq_detect.sv
module sim_swstore_seq_detect;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [14:0] acc_addr = '0;
  logic        store_done = 1'b0;
  logic        store_req;
  logic [2:0]  match_idx;

  always #2 clk = ~clk;

  swstore_seq_detect u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .store_done(store_done),
    .store_req(store_req), .match_idx(match_idx)
  );

  // Key slots as given by the requirements (slot 0 first).
  logic [14:0] key [6] = '{15'h1A5C, 15'h6B21, 15'h0F93, 15'h54E7, 15'h2C0D, 15'h7396};

  int  checks = 0;
  int  fails = 0;
  int  m_pos = 0;
  bit  m_pend = 0;
  bit  m_req = 0;
  bit  finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected behaviour of one clock, stated from the requirements.
  function automatic void model(bit v, bit w, logic [14:0] a, bit d);
    m_req = 0;
    if (m_pend) begin
      if (d) m_pend = 0;
    end else if (v) begin
      if (!w && a == key[m_pos]) begin
        if (m_pos == 5) begin m_req = 1; m_pos = 0; m_pend = 1; end
        else m_pos = m_pos + 1;
      end else if (!w && a == key[0]) m_pos = 1;
      else m_pos = 0;
    end
  endfunction

  task automatic cyc(bit v, bit w, logic [14:0] a, bit d, string tag);
    acc_valid = v; acc_write = w; acc_addr = a; store_done = d;
    @(negedge clk);
    model(v, w, a, d);
    chk({tag, " idx"}, 32'(match_idx), 32'(m_pos));
    chk({tag, " req"}, 32'(store_req), 32'(m_req));
  endtask

  task automatic rd(logic [14:0] a, string tag); cyc(1, 0, a, 0, tag); endtask

  task automatic key_reads(int from, int upto, string tag);
    for (int i = from; i <= upto; i++) rd(key[i], tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset idx", 32'(match_idx), 0);
    chk("R1 reset req", 32'(store_req), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, "R1");

    // Full key, then the same key while pending.
    key_reads(0, 4, "R2");
    rd(key[5], "R3");
    chk("R3 pulse width", 32'(store_req), 1);
    key_reads(0, 5, "R7");
    cyc(1, 1, key[0], 0, "R7");
    cyc(0, 0, 0, 1, "R8");
    key_reads(0, 5, "R8");
    cyc(0, 0, 0, 1, "R8");

    // Aborts.
    key_reads(0, 2, "R2");
    cyc(1, 1, key[3], 0, "R4");
    key_reads(0, 4, "R2");
    cyc(1, 1, key[5], 0, "R4");
    rd(key[5], "R4");
    key_reads(0, 1, "R2");
    rd(15'h0001, "R5");
    rd(key[2], "R5");
    key_reads(0, 3, "R2");
    rd(key[0], "R6");
    rd(key[0], "R6");
    key_reads(1, 5, "R6");
    cyc(0, 0, 0, 1, "R8");

    // Stray done with nothing pending, and idle cycles inside a key.
    cyc(0, 0, 0, 1, "R8");
    key_reads(0, 1, "R9");
    cyc(0, 1, key[2], 0, "R9");
    cyc(0, 0, key[0], 0, "R9");
    cyc(0, 0, 15'h7FFF, 1, "R9");
    key_reads(2, 5, "R9");
    cyc(0, 0, 0, 1, "R8");

    // Weighted random traffic.
    for (int n = 0; n < 4000; n++) begin
      int pick = $urandom_range(0, 99);
      bit v = ($urandom_range(0, 9) != 0);
      bit d = ($urandom_range(0, 11) == 0);
      logic [14:0] a;
      bit w = 0;
      if (pick < 60)      a = key[m_pos];
      else if (pick < 72) a = key[0];
      else if (pick < 90) a = 15'($urandom);
      else begin a = 15'($urandom); w = 1; end
      cyc(v, w, a, d, "R2 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule